// File: doc/BRIEF.md
# Inter-Core Interrupt Mailbox with Clock Pause

This block sits between a control core and a signal-processing core that share a memory region. Each core has its own small register port. A write by the control core to its request register posts a command word. The block then raises a level start interrupt toward the processing core. If that core's clock had been paused, the block first turns its clock-enable back on and only presents the interrupt once the clock has run for a few cycles.

When the processing core finishes, it writes its done register with a result word. This raises a level completion interrupt toward the control core. The control core acknowledges it, and the block returns to idle. If the software pause bit is set and no request is queued, the processing core's clock-enable is then dropped. A request that arrives while a job is still in flight is held in a one-deep queue and delivered once the completion has been acknowledged. The shared memory and the clock-gating cell sit outside the block. The memory stays reachable whatever the clock-enable does.

Top module: `icc_mailbox`

## Requirements
- R1: In idle, a control write to address 0 latches the write data as the command, which the processing core reads at its address 0. The block leaves idle at once and raises `start_irq` after the wake delay.
- R2: Control address 2 bit 0 is the pause-enable bit, reset value 0. While it is 0, `core_clk_en` stays 1.
- R3: `start_irq` rises exactly WAKE_CYC (default 2) cycles after the clock edge that captures the request. `core_clk_en` has been 1 for at least the two cycles before that edge.
- R4: A request written while a job is in flight sets the pending flag and stores its data, and a later one replaces the stored data. After the completion is acknowledged, the stored command becomes the current command and is started.
- R5: `core_clk_en` is 0 only while the block is idle, no request is pending and pause-enable is 1. It falls after the completion acknowledge and rises on the edge that captures a new request.
- R6: `start_irq` stays 1 until the processing core writes its address 0 with bit 0 set. A write there with bit 0 clear has no effect.
- R7: While started, a processing-core write to its address 1 latches the data as the result, readable at control address 1. It also raises `done_irq`, which stays 1 until the control core writes its address 1 with bit 0 set.
- R8: A done write while not started leaves the result, the status and `done_irq` unchanged. A control acknowledge while no completion is posted has no effect.
- R9: Control address 0 reads the status: bit 4 start interrupt, bit 3 clock-enable, bit 2 busy (waking or started), bit 1 pending, bit 0 completion interrupt. Processing-core address 1 bit 0 reads the start interrupt.
- R10: After reset, both interrupts, busy and pending are 0, the command and result are 0, and `core_clk_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control-core write strobe |
| ctl_addr | input | 2 | Control-core register address (read and write) |
| ctl_wdata | input | DATA_W | Control-core write data |
| ctl_rdata | output | DATA_W | Control-core read data |
| core_wr_en | input | 1 | Processing-core write strobe |
| core_addr | input | 2 | Processing-core register address (read and write) |
| core_wdata | input | DATA_W | Processing-core write data |
| core_rdata | output | DATA_W | Processing-core read data |
| start_irq | output | 1 | Level start interrupt to the processing core |
| done_irq | output | 1 | Level completion interrupt to the control core |
| core_clk_en | output | 1 | Clock-enable for the processing core's gating cell |

## Verification
Every register write lands on the clock edge that follows its strobe. Interrupt clears, the pending flag, the command, the result and busy are therefore visible one cycle later. The clock-enable follows the state one edge later as well, except on a request out of idle, where it rises on that same edge. The start interrupt comes WAKE_CYC edges after the request. The table-driven steps wait three idle cycles after each write before they read the status and command, which is past every delay. The wake test instead samples on each falling edge right after the request and checks that the clock-enable is on from the first cycle while the start interrupt stays low for exactly two cycles.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAKE = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } mbx_state_e;

  localparam int REG_AW = 2;

  // control-side addresses
  localparam logic [REG_AW-1:0] CA_REQ  = 2'd0;  // write: request, read: status
  localparam logic [REG_AW-1:0] CA_ACK  = 2'd1;  // write: ack,     read: result
  localparam logic [REG_AW-1:0] CA_CFG  = 2'd2;  // pause enable

  // processing-side addresses
  localparam logic [REG_AW-1:0] PA_CLR  = 2'd0;  // write: clear start, read: command
  localparam logic [REG_AW-1:0] PA_DONE = 2'd1;  // write: done,        read: status

  localparam int STAT_W = 5;

endpackage

// File: rtl/mbx_ctl_port.sv
module mbx_ctl_port
  import mbx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [REG_AW-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [STAT_W-1:0]       status,
  input  logic [DATA_W-1:0]       result,
  output logic                    req_stb,
  output logic                    ack_stb,
  output logic                    pause_en,
  output logic [DATA_W-1:0]       rdata
);

  logic pause_en_n;

  always_comb begin
    req_stb = wr_en && (addr == CA_REQ);
    ack_stb = wr_en && (addr == CA_ACK) && wdata[0];
  end

  always_comb begin
    pause_en_n = pause_en;
    if (wr_en && (addr == CA_CFG)) begin
      pause_en_n = wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pause_en <= 1'b0;
    end else begin
      pause_en <= pause_en_n;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      CA_REQ:  rdata[STAT_W-1:0] = status;
      CA_ACK:  rdata = result;
      CA_CFG:  rdata[0] = pause_en;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/mbx_core_port.sv
module mbx_core_port
  import mbx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                    wr_en,
  input  logic [REG_AW-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [DATA_W-1:0]       cmd,
  input  logic                    start_irq,
  output logic                    clr_stb,
  output logic                    done_stb,
  output logic [DATA_W-1:0]       rdata
);

  always_comb begin
    clr_stb  = wr_en && (addr == PA_CLR) && wdata[0];
    done_stb = wr_en && (addr == PA_DONE);
  end

  always_comb begin
    rdata = '0;
    if (addr == PA_CLR) begin
      rdata = cmd;
    end else if (addr == PA_DONE) begin
      rdata[0] = start_irq;
    end
  end

endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
  import mbx_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int WAKE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_stb,
  input  logic [DATA_W-1:0] req_data,
  input  logic              ack_stb,
  input  logic              clr_stb,
  input  logic              done_stb,
  input  logic [DATA_W-1:0] done_data,
  input  logic              pause_en,
  output logic              start_irq,
  output logic              done_irq,
  output logic              clk_en,
  output logic              pending,
  output logic              busy,
  output logic [DATA_W-1:0] cmd,
  output logic [DATA_W-1:0] result
);

  localparam int CNT_W = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_CYC - 1);

  mbx_state_e        state, state_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic              start_n, done_n, clk_en_n, pend_n;
  logic [DATA_W-1:0] pcmd, pcmd_n, cmd_n, result_n;

  always_comb begin
    state_n  = state;
    cnt_n    = cnt;
    start_n  = start_irq;
    done_n   = done_irq;
    pend_n   = pending;
    pcmd_n   = pcmd;
    cmd_n    = cmd;
    result_n = result;

    if (clr_stb) begin
      start_n = 1'b0;
    end

    unique case (state)
      ST_IDLE: begin
        if (req_stb) begin
          state_n = ST_WAKE;
          cmd_n   = req_data;
          cnt_n   = '0;
        end
      end
      ST_WAKE: begin
        if (req_stb) begin
          pend_n = 1'b1;
          pcmd_n = req_data;
        end
        if (cnt == CNT_LAST) begin
          state_n = ST_RUN;
          start_n = 1'b1;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_RUN: begin
        if (req_stb) begin
          pend_n = 1'b1;
          pcmd_n = req_data;
        end
        if (done_stb) begin
          state_n  = ST_DONE;
          done_n   = 1'b1;
          result_n = done_data;
        end
      end
      ST_DONE: begin
        if (ack_stb) begin
          done_n = 1'b0;
          cnt_n  = '0;
          if (pending) begin
            state_n = ST_WAKE;
            cmd_n   = pcmd;
            pend_n  = req_stb;
            if (req_stb) begin
              pcmd_n = req_data;
            end
          end else if (req_stb) begin
            state_n = ST_WAKE;
            cmd_n   = req_data;
          end else begin
            state_n = ST_IDLE;
          end
        end else if (req_stb) begin
          pend_n = 1'b1;
          pcmd_n = req_data;
        end
      end
      default: state_n = ST_IDLE;
    endcase

    clk_en_n = !((state_n == ST_IDLE) && pause_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      start_irq <= 1'b0;
      done_irq  <= 1'b0;
      pending   <= 1'b0;
      pcmd      <= '0;
      cmd       <= '0;
      result    <= '0;
      clk_en    <= 1'b1;
    end else begin
      state     <= state_n;
      cnt       <= cnt_n;
      start_irq <= start_n;
      done_irq  <= done_n;
      pending   <= pend_n;
      pcmd      <= pcmd_n;
      cmd       <= cmd_n;
      result    <= result_n;
      clk_en    <= clk_en_n;
    end
  end

  always_comb begin
    busy = (state == ST_WAKE) || (state == ST_RUN);
  end

  AST_WAKE_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_irq) |-> ($past(clk_en, 1) && $past(clk_en, 2))); // R3

  AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (start_irq && !clr_stb) |=> start_irq); // R6

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_irq && !ack_stb) |=> done_irq); // R7

  AST_PAUSE_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> ((state == ST_IDLE) && !pending && !start_irq && !done_irq)); // R5

  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !(ack_stb && (state == ST_DONE))) |=> pending); // R4

  AST_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_stb && (state != ST_RUN)) |=> $stable(result)); // R8

endmodule

// File: rtl/icc_mailbox.sv
module icc_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int WAKE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr_en,
  input  logic [1:0]        ctl_addr,
  input  logic [DATA_W-1:0] ctl_wdata,
  output logic [DATA_W-1:0] ctl_rdata,
  input  logic              core_wr_en,
  input  logic [1:0]        core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic [DATA_W-1:0] core_rdata,
  output logic              start_irq,
  output logic              done_irq,
  output logic              core_clk_en
);

  logic              req_stb, ack_stb, pause_en;
  logic              clr_stb, done_stb;
  logic              pending, busy;
  logic [DATA_W-1:0] cmd, result;
  logic [STAT_W-1:0] status;

  always_comb begin
    status = {start_irq, core_clk_en, busy, pending, done_irq};
  end

  mbx_ctl_port #(.DATA_W(DATA_W)) ctl_port_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctl_wr_en),
    .addr     (ctl_addr),
    .wdata    (ctl_wdata),
    .status   (status),
    .result   (result),
    .req_stb  (req_stb),
    .ack_stb  (ack_stb),
    .pause_en (pause_en),
    .rdata    (ctl_rdata)
  );

  mbx_core_port #(.DATA_W(DATA_W)) core_port_i (
    .wr_en     (core_wr_en),
    .addr      (core_addr),
    .wdata     (core_wdata),
    .cmd       (cmd),
    .start_irq (start_irq),
    .clr_stb   (clr_stb),
    .done_stb  (done_stb),
    .rdata     (core_rdata)
  );

  mbx_seq #(.DATA_W(DATA_W), .WAKE_CYC(WAKE_CYC)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_stb   (req_stb),
    .req_data  (ctl_wdata),
    .ack_stb   (ack_stb),
    .clr_stb   (clr_stb),
    .done_stb  (done_stb),
    .done_data (core_wdata),
    .pause_en  (pause_en),
    .start_irq (start_irq),
    .done_irq  (done_irq),
    .clk_en    (core_clk_en),
    .pending   (pending),
    .busy      (busy),
    .cmd       (cmd),
    .result    (result)
  );

endmodule

// File: tb/icc_mailbox_tb.sv
`timescale 1ns/1ps
module icc_mailbox_tb_top;

  localparam int DW = 16;
  localparam int NSTEP = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_wr_en = 1'b0;
  logic [1:0]    ctl_addr = 2'd0;
  logic [DW-1:0] ctl_wdata = '0;
  logic [DW-1:0] ctl_rdata;
  logic          core_wr_en = 1'b0;
  logic [1:0]    core_addr = 2'd0;
  logic [DW-1:0] core_wdata = '0;
  logic [DW-1:0] core_rdata;
  logic          start_irq, done_irq, core_clk_en;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  icc_mailbox #(.DATA_W(DW), .WAKE_CYC(2)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr_en(ctl_wr_en), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .core_wr_en(core_wr_en), .core_addr(core_addr), .core_wdata(core_wdata), .core_rdata(core_rdata),
    .start_irq(start_irq), .done_irq(done_irq), .core_clk_en(core_clk_en)
  );

  // {port(1=core), addr[1:0], data[15:0], exp status[4:0] {start,clk,busy,pend,done}, exp cmd[15:0]}
  localparam logic [39:0] STEPS [NSTEP] = '{
    {1'b0, 2'd2, 16'h0001, 5'b00000, 16'h0000}, // pause on, idle -> clock off   R5
    {1'b0, 2'd0, 16'h00A1, 5'b11100, 16'h00A1}, // request wakes core           R1
    {1'b0, 2'd0, 16'h00B2, 5'b11110, 16'h00A1}, // request while busy pends     R4
    {1'b1, 2'd0, 16'h0001, 5'b01110, 16'h00A1}, // core clears start            R6
    {1'b1, 2'd1, 16'h5511, 5'b01011, 16'h00A1}, // core done                    R7
    {1'b0, 2'd1, 16'h0001, 5'b11100, 16'h00B2}, // ack delivers pending         R4
    {1'b1, 2'd0, 16'h0001, 5'b01100, 16'h00B2}, //                              R6
    {1'b1, 2'd1, 16'h7722, 5'b01001, 16'h00B2}, //                              R7
    {1'b0, 2'd1, 16'h0001, 5'b00000, 16'h00B2}, // ack, nothing pending, pause  R5
    {1'b0, 2'd2, 16'h0000, 5'b01000, 16'h00B2}, // pause off -> clock on        R2
    {1'b1, 2'd1, 16'h3333, 5'b01000, 16'h00B2}, // done while idle ignored      R8
    {1'b0, 2'd1, 16'h0001, 5'b01000, 16'h00B2}, // ack while idle ignored       R8
    {1'b0, 2'd0, 16'h00C3, 5'b11100, 16'h00C3}, //                              R1
    {1'b1, 2'd0, 16'h0001, 5'b01100, 16'h00C3}, //                              R6
    {1'b1, 2'd1, 16'h0001, 5'b01001, 16'h00C3}, //                              R7
    {1'b0, 2'd1, 16'h0001, 5'b01000, 16'h00C3}  //                              R9
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic core, input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    if (core) begin
      core_wr_en = 1'b1; core_addr = a; core_wdata = d;
    end else begin
      ctl_wr_en = 1'b1; ctl_addr = a; ctl_wdata = d;
    end
    @(negedge clk);
    core_wr_en = 1'b0;
    ctl_wr_en  = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_ctl(input logic [1:0] a, output logic [DW-1:0] v);
    ctl_addr = a; #0.5; v = ctl_rdata;
  endtask

  task automatic rd_core(input logic [1:0] a, output logic [DW-1:0] v);
    core_addr = a; #0.5; v = core_rdata;
  endtask

  task automatic finish_all;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    finish_all();
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd_ctl(2'd0, v);  chk("R10 status", 32'(v), 32'h08);
    rd_core(2'd0, v); chk("R10 cmd", 32'(v), 32'h0);
    rd_ctl(2'd1, v);  chk("R10 result", 32'(v), 32'h0);
    rd_ctl(2'd2, v);  chk("R2 pause reset", 32'(v), 32'h0);
    chk("R10 irqs/clk", {29'd0, start_irq, done_irq, core_clk_en}, 32'h1);

    // table walk
    for (int i = 0; i < NSTEP; i++) begin
      wr(STEPS[i][39], STEPS[i][38:37], STEPS[i][36:21]);
      idle(3);
      rd_ctl(2'd0, v);
      chk($sformatf("R9 step %0d status", i), 32'(v), 32'(STEPS[i][20:16]));
      rd_core(2'd0, v);
      chk($sformatf("R1 step %0d cmd", i), 32'(v), 32'(STEPS[i][15:0]));
      chk($sformatf("R9 step %0d pins", i), {29'd0, start_irq, core_clk_en, done_irq},
          {29'd0, STEPS[i][20], STEPS[i][19], STEPS[i][16]});
    end

    // R7 result and R8 ignored done
    rd_ctl(2'd1, v); chk("R7 result", 32'(v), 32'h0001);
    wr(1'b1, 2'd1, 16'hDEAD);
    idle(2);
    rd_ctl(2'd1, v); chk("R8 result kept", 32'(v), 32'h0001);
    chk("R8 done_irq low", 32'(done_irq), 32'h0);

    // R3 wake timing from paused
    wr(1'b0, 2'd2, 16'h0001);
    idle(3);
    chk("R5 paused", 32'(core_clk_en), 32'h0);
    wr(1'b0, 2'd0, 16'h0042);
    chk("R3 clk_en on at request edge", {30'd0, core_clk_en, start_irq}, 32'h2);
    @(negedge clk);
    chk("R3 start still low", {30'd0, core_clk_en, start_irq}, 32'h2);
    @(negedge clk);
    chk("R3 start after two cycles", {30'd0, core_clk_en, start_irq}, 32'h3);

    // R6 start holds, bit0-clear write ignored
    idle(8);
    wr(1'b1, 2'd0, 16'h0000);
    idle(1);
    chk("R6 start held", 32'(start_irq), 32'h1);
    rd_core(2'd1, v); chk("R9 core status", 32'(v), 32'h1);

    // R4 pending replaced by latest
    wr(1'b0, 2'd0, 16'h0051);
    wr(1'b0, 2'd0, 16'h0052);
    wr(1'b1, 2'd0, 16'h0001);
    wr(1'b1, 2'd1, 16'h0099);
    idle(1);
    chk("R7 done_irq up", 32'(done_irq), 32'h1);
    wr(1'b0, 2'd1, 16'h0000);
    idle(2);
    chk("R7 ack bit0 clear ignored", 32'(done_irq), 32'h1);
    wr(1'b0, 2'd1, 16'h0001);
    idle(3);
    rd_core(2'd0, v); chk("R4 latest pending delivered", 32'(v), 32'h0052);
    rd_ctl(2'd0, v);  chk("R4 pending cleared", 32'(v), 32'h1C);

    // drain, R5 clock drops after final ack
    wr(1'b1, 2'd0, 16'h0001);
    wr(1'b1, 2'd1, 16'h0007);
    idle(1);
    chk("R5 clock held while done posted", 32'(core_clk_en), 32'h1);
    wr(1'b0, 2'd1, 16'h0001);
    idle(1);
    chk("R5 clock paused after ack", 32'(core_clk_en), 32'h0);

    finish_all();
  end

endmodule